// File: doc/BRIEF.md
# Sleep, Wake and Stop Power Sequencer

This block moves a processor between three power levels: running, sleeping and stopped. The core raises a sleep request. The block holds that request until the core reports that it is idle. It then gates the core clock enable and drives its active-low power-down status low. Sleep ends when an asynchronous active-low wake input is held low long enough. The block then restores the core clock, releases power-down and issues a one-cycle restart pulse.

While the block is asleep, an active-low stop input takes it one level deeper. In the stop level the PLL enable drops as well as the core clock enable. A wake from stop turns the PLL back on first. The block then waits a lock delay, given as a cycle count on an input, before it restores the core clock and restarts execution. The PLL and the clock gating cells themselves are outside the block; they are represented here only by the enable outputs.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While reset is held and right after it is released, pdown_no=1, core_clk_en_o=1, pll_en_o=1 and restart_o=0.
- R2: A sleep request is held until core_idle_i is high. At the first rising edge where the request is held and core_idle_i=1, the state becomes sleep, and pdown_no and core_clk_en_o go to 0 at that edge. Until then both stay at 1.
- R3: During sleep, pdown_no=0, core_clk_en_o=0 and pll_en_o=1.
- R4: A wake_ni low pulse of at least FILTER_LEN cycles (default 2) wakes the block. restart_o rises at the rising edge SYNC_STAGES+FILTER_LEN cycles after the first edge that samples wake_ni low (4 edges by default).
- R5: A wake_ni low pulse of one cycle (shorter than FILTER_LEN) never wakes the block.
- R6: pdown_no returns to 1 and core_clk_en_o returns to 1 at the same edge where restart_o is asserted.
- R7: stop_ni=0 sampled during sleep moves the block to stop at the next edge: pll_en_o=0, core_clk_en_o=0, pdown_no=0. It stays there after stop_ni returns high.
- R8: stop_ni has no effect while the block is running; all outputs keep their run values.
- R9: A wake accepted in stop sets pll_en_o=1 at the acceptance edge, keeps core_clk_en_o=0 for lock_cycles_i+1 further cycles, and then asserts restart_o together with core_clk_en_o=1.
- R10: wake_ni has no effect while the block is running.
- R11: restart_o is high for exactly one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep request from the core, captured at an edge |
| core_idle_i | input | 1 | Core reports that it has drained and is idle |
| wake_ni | input | 1 | Asynchronous active-low wake |
| stop_ni | input | 1 | Active-low request to go from sleep to stop |
| lock_cycles_i | input | LOCK_W | PLL lock wait in cycles after a wake from stop |
| pdown_no | output | 1 | Active-low power-down status |
| core_clk_en_o | output | 1 | Core clock enable |
| pll_en_o | output | 1 | PLL enable |
| restart_o | output | 1 | One-cycle restart pulse |

## Verification
The bench uses SYNC_STAGES=2 and FILTER_LEN=2, so a two-cycle wake pulse sits exactly at the acceptance edge and a one-cycle pulse just below it. LOCK_W is cut to 8 so that the largest lock count, 255, can be run in full. That exercises the zero-wait and maximum-wait relock paths as well as random counts in between.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_ENTER  = 3'd1,
    PS_SLEEP  = 3'd2,
    PS_STOP   = 3'd3,
    PS_RELOCK = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_ni,
  output logic wake_seen_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= wake_ni;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end
  assign sync_out = sync_q[SYNC_STAGES-1];

  if (FILTER_LEN <= 1) begin : g_nofilt
    assign wake_seen_o = ~sync_out;
  end else begin : g_filt
    logic [FILTER_LEN-2:0] hist_q;
    for (genvar h = 0; h < FILTER_LEN-1; h++) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hist_q[h] <= 1'b1;
        else if (h == 0) hist_q[h] <= sync_out;
        else             hist_q[h] <= hist_q[(h == 0) ? 0 : h-1];
      end
    end
    // accept only when every sample in the window is low
    assign wake_seen_o = ~|{hist_q, sync_out};
  end
endmodule

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
  parameter int LOCK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LOCK_W-1:0] load_val_i,
  input  logic              run_i,
  output logic              done_o
);
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_sleep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic core_idle_i,
  input  logic stop_ni,
  input  logic wake_seen_i,
  input  logic lock_done_i,
  output logic lock_load_o,
  output logic relock_o,
  output logic pdown_no,
  output logic core_clk_en_o,
  output logic pll_en_o,
  output logic restart_o
);
  pwr_state_e st_q, st_d;
  logic       restart_d;

  always_comb begin
    st_d        = st_q;
    restart_d   = 1'b0;
    lock_load_o = 1'b0;
    unique case (st_q)
      PS_RUN:    if (sleep_req_i) st_d = core_idle_i ? PS_SLEEP : PS_ENTER;
      PS_ENTER:  if (core_idle_i) st_d = PS_SLEEP;
      PS_SLEEP: begin
        if (wake_seen_i) begin
          st_d      = PS_RUN;
          restart_d = 1'b1;
        end else if (!stop_ni) begin
          st_d = PS_STOP;
        end
      end
      PS_STOP: begin
        if (wake_seen_i) begin
          st_d        = PS_RELOCK;
          lock_load_o = 1'b1;
        end
      end
      PS_RELOCK: begin
        if (lock_done_i) begin
          st_d      = PS_RUN;
          restart_d = 1'b1;
        end
      end
      default:   st_d = PS_RUN;
    endcase
  end

  assign relock_o = (st_q == PS_RELOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= PS_RUN;
      pdown_no      <= 1'b1;
      core_clk_en_o <= 1'b1;
      pll_en_o      <= 1'b1;
      restart_o     <= 1'b0;
    end else begin
      st_q          <= st_d;
      pdown_no      <= (st_d == PS_RUN) || (st_d == PS_ENTER);
      core_clk_en_o <= (st_d == PS_RUN) || (st_d == PS_ENTER);
      pll_en_o      <= (st_d != PS_STOP);
      restart_o     <= restart_d;
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 2,
  parameter int LOCK_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              core_idle_i,
  input  logic              wake_ni,
  input  logic              stop_ni,
  input  logic [LOCK_W-1:0] lock_cycles_i,
  output logic              pdown_no,
  output logic              core_clk_en_o,
  output logic              pll_en_o,
  output logic              restart_o
);
  logic wake_seen, lock_load, relock, lock_done;

  pwr_wake_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN (FILTER_LEN)
  ) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_ni    (wake_ni),
    .wake_seen_o(wake_seen)
  );

  pwr_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (lock_load),
    .load_val_i(lock_cycles_i),
    .run_i     (relock),
    .done_o    (lock_done)
  );

  pwr_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .core_idle_i  (core_idle_i),
    .stop_ni      (stop_ni),
    .wake_seen_i  (wake_seen),
    .lock_done_i  (lock_done),
    .lock_load_o  (lock_load),
    .relock_o     (relock),
    .pdown_no     (pdown_no),
    .core_clk_en_o(core_clk_en_o),
    .pll_en_o     (pll_en_o),
    .restart_o    (restart_o)
  );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic core_idle_i,
  input logic pdown_no,
  input logic core_clk_en_o,
  input logic pll_en_o,
  input logic restart_o
);
  // R3
  sleep_clk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdown_no |-> !core_clk_en_o);

  // R2
  sleep_entry_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pdown_no) |-> $past(core_idle_i));

  // R6
  wake_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdown_no) |-> (restart_o && core_clk_en_o));

  // R11
  restart_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  // R7
  stop_from_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_o) |-> ($past(!pdown_no) && !pdown_no));

  // R8
  stop_ignored_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_no |=> pll_en_o);

  // R9
  relock_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> !core_clk_en_o);
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_idle_i  (core_idle_i),
  .pdown_no     (pdown_no),
  .core_clk_en_o(core_clk_en_o),
  .pll_en_o     (pll_en_o),
  .restart_o    (restart_o)
);

// File: tb/tb_pwr_sleep_ctrl.sv
module tb_pwr_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int FILT = 2;
  localparam int LW   = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_req_i = 1'b0;
  logic          core_idle_i = 1'b0;
  logic          wake_ni = 1'b1;
  logic          stop_ni = 1'b1;
  logic [LW-1:0] lock_cycles_i = '0;
  logic          pdown_no, core_clk_en_o, pll_en_o, restart_o;

  int n_cmp = 0;
  int n_bad = 0;

  pwr_sleep_ctrl #(.SYNC_STAGES(SYNC), .FILTER_LEN(FILT), .LOCK_W(LW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i),
    .core_idle_i(core_idle_i), .wake_ni(wake_ni), .stop_ni(stop_ni),
    .lock_cycles_i(lock_cycles_i), .pdown_no(pdown_no),
    .core_clk_en_o(core_clk_en_o), .pll_en_o(pll_en_o), .restart_o(restart_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int wake_lat();
    return SYNC + FILT;
  endfunction

  function automatic int relock_lat(int lk);
    return SYNC + FILT + lk + 1;
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, bit pd, bit ce, bit pe, bit rs);
    chk(tag, "pdown_no", pdown_no, pd);
    chk(tag, "core_clk_en_o", core_clk_en_o, ce);
    chk(tag, "pll_en_o", pll_en_o, pe);
    chk(tag, "restart_o", restart_o, rs);
  endtask

  // R2 / R3: request while busy for 'busy' cycles
  task automatic go_sleep(int busy);
    @(negedge clk_i);
    sleep_req_i = 1'b1;
    core_idle_i = (busy == 0);
    for (int i = 1; i <= busy + 3; i++) begin
      @(negedge clk_i);
      chk("R2", "pdown_no", pdown_no, i <= busy);
      chk("R2", "core_clk_en_o", core_clk_en_o, i <= busy);
      chk("R3", "pll_en_o", pll_en_o, 1'b1);
      if (i == 1) sleep_req_i = 1'b0;
      if (i == busy) core_idle_i = 1'b1;
    end
    core_idle_i = 1'b0;
  endtask

  // R7
  task automatic enter_stop();
    @(negedge clk_i);
    stop_ni = 1'b0;
    @(negedge clk_i);
    chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    stop_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // R4 R5 R6 R9 R11
  task automatic wake_seq(int pulse, bit from_stop, int lk);
    int  total;
    bit  ok;
    total = from_stop ? relock_lat(lk) : wake_lat();
    ok    = (pulse >= FILT);
    @(negedge clk_i);
    wake_ni       = 1'b0;
    lock_cycles_i = LW'(lk);
    for (int i = 1; i <= total + 3; i++) begin
      @(negedge clk_i);
      chk(ok ? "R4" : "R5", "restart_o", restart_o, ok && (i == total));
      chk("R6", "pdown_no", pdown_no, ok && (i >= total));
      chk("R6", "core_clk_en_o", core_clk_en_o, ok && (i >= total));
      if (from_stop) chk("R9", "pll_en_o", pll_en_o, ok && (i >= wake_lat()));
      else           chk("R3", "pll_en_o", pll_en_o, 1'b1);
      if (i == total + 1) chk("R11", "restart_o", restart_o, 1'b0);
      if (i == pulse) wake_ni = 1'b1;
    end
    wake_ni = 1'b1;
    repeat (SYNC + FILT + 1) @(negedge clk_i);
  endtask

  // R8
  task automatic stop_in_run();
    @(negedge clk_i);
    stop_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk_all("R8", 1'b1, 1'b1, 1'b1, 1'b0);
    end
    stop_ni = 1'b1;
  endtask

  // R10
  task automatic wake_in_run();
    @(negedge clk_i);
    wake_ni = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk_all("R10", 1'b1, 1'b1, 1'b1, 1'b0);
    end
    wake_ni = 1'b1;
    repeat (SYNC + FILT + 1) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int busy, pulse, lk;
    bit to_stop;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    chk_all("R1", 1'b1, 1'b1, 1'b1, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_all("R1", 1'b1, 1'b1, 1'b1, 1'b0);

    stop_in_run();
    wake_in_run();

    go_sleep(0);
    wake_seq(2, 1'b0, 0);
    go_sleep(3);
    wake_seq(1, 1'b0, 0);
    wake_seq(5, 1'b0, 0);
    go_sleep(1);
    enter_stop();
    wake_seq(1, 1'b1, 3);
    wake_seq(2, 1'b1, 0);
    go_sleep(2);
    enter_stop();
    wake_seq(3, 1'b1, 255);
    stop_in_run();

    for (int n = 0; n < 40; n++) begin
      busy    = $urandom_range(0, 6);
      to_stop = 1'($urandom_range(0, 1));
      pulse   = $urandom_range(1, 6);
      lk      = $urandom_range(0, 20);
      go_sleep(busy);
      if (to_stop) enter_stop();
      wake_seq(pulse, to_stop, lk);
      if (pulse < FILT) wake_seq(FILT + 1, to_stop, lk);
      if ($urandom_range(0, 3) == 0) wake_in_run();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule